// File: doc/BRIEF.md
# SD Card SPI Single-Block Data Mover

This block carries one data block between a local byte buffer and a memory card on a byte-wide SPI exchange port. It runs after a command engine elsewhere has issued the read-block or write-block command and seen it accepted. One `start` pulse moves one block. `is_write` chooses the direction. Every byte on the wire goes through the exchange port: the block raises `xch_start` with a byte to send, and the port answers with `xch_done` and the byte it shifted in.

On a read, the block polls the card until the start token arrives. It then delivers the payload one byte at a time, with an index and a one-cycle valid. It clocks the two check bytes in and drops them.

On a write, the block reads the payload from the buffer by index and frames it with the start token and two filler check bytes. It then decodes the card's data-response token and waits out the card's busy period. Both waits are bounded. Each transfer ends with chip select released, one trailing filler byte, and a `done` pulse with status.

Top module: `sd_blk_xfer`

## Requirements
- R1: On a read, the block sends 0xFF on every poll until the returned byte is exactly 0xFE. Any other value, including 0xFF and 0xFC, keeps it hunting. After the token it captures exactly BLK_LEN payload bytes.
- R2: On a read, the block clocks in two further bytes after the payload, sending 0xFF each time, and delivers neither to the buffer.
- R3: On a write, the bytes sent are 0xFE, then BLK_LEN payload bytes taken from `wr_data` at `wr_idx` = 0 through BLK_LEN-1 in order, then 0xFF twice.
- R4: After the two filler bytes, the block sends one 0xFF and masks the returned byte with 0x1F. If the result is 0x05, the write is accepted and the busy wait starts.
- R5: Any other masked value rejects the write. There is no busy wait: the block goes straight to the trailing byte and sets `err_reject`. `rej_kind` reads 1 for a masked 0x0B (CRC fault), 2 for a masked 0x0D (write fault) and 3 for any other value.
- R6: During the busy wait, the block sends 0xFF for as long as the card returns 0x00. The first non-zero byte ends the wait without an error.
- R7: `cs_n` falls at `start` and stays low for every exchange of the transfer except the last. The last exchange is a single 0xFF sent with `cs_n` high.
- R8: If HUNT_LIMIT polls in a row return something other than 0xFE, the block sets `err_timeout`, skips the payload and goes to the trailing byte.
- R9: If BUSY_LIMIT busy polls in a row return 0x00, the block sets `err_timeout` and goes to the trailing byte.
- R10: After reset, `cs_n` is 1 and `done`, `xch_start`, `rd_valid`, `err_reject` and `err_timeout` are 0. `done` is a one-cycle pulse issued after the trailing byte. The error flags hold their values until the next `start`, and at most one of them is set.
- R11: Each read byte is presented for exactly one cycle on `rd_valid`, with `rd_idx` counting 0 through BLK_LEN-1 in wire order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | One-cycle request to move a block (taken only when idle) |
| is_write | input | 1 | 1 = write block to card, 0 = read block from card |
| done | output | 1 | One-cycle pulse when the transfer has fully ended |
| err_reject | output | 1 | Write refused by the card's response token |
| rej_kind | output | 2 | Reject reason: 1 CRC fault, 2 write fault, 3 other |
| err_timeout | output | 1 | Token hunt or busy wait ran out |
| cs_n | output | 1 | Card chip select, active low |
| xch_start | output | 1 | One-cycle request for a byte exchange |
| xch_tx | output | 8 | Byte to send, valid with `xch_start` |
| xch_done | input | 1 | Exchange finished, `xch_rx` valid |
| xch_rx | input | 8 | Byte received in the exchange |
| rd_valid | output | 1 | Read byte valid, one cycle |
| rd_idx | output | log2(BLK_LEN) | Buffer index of the read byte |
| rd_data | output | 8 | Read byte |
| wr_idx | output | log2(BLK_LEN) | Buffer index of the write byte wanted |
| wr_data | input | 8 | Write byte for `wr_idx`, combinational from the buffer |

## Verification
The bench runs reads with a start token that arrives at once, after a few polls, on the last poll allowed, and never. This tells an off-by-one in the hunt bound apart from a real timeout. Some hunt fill bytes are non-0xFF values, which shows that only an exact 0xFE starts the payload.

Writes run with an accepted token whose top bits are junk, with a CRC-fault token, with a write-fault token and with an unlisted token. Busy periods are zero polls, one short of the bound and at the bound. Random transfers mix all of these with random payloads. Every exchange is logged and compared with the expected byte stream and chip-select level, so a missing, extra or misordered byte is caught.

// File: rtl/sdx_pkg.sv
package sdx_pkg;
   typedef enum logic [3:0] {
      S_IDLE, S_HUNT, S_RDAT, S_RCRC,
      S_WTOK, S_WDAT, S_WCRC, S_WRSP, S_WBSY, S_TRAIL
   } sdx_state_t;

   localparam logic [7:0] TOK_START = 8'hFE;
   localparam logic [7:0] FILL_BYTE = 8'hFF;
   localparam logic [4:0] RESP_OK   = 5'h05;
   localparam logic [4:0] RESP_CRC  = 5'h0B;
   localparam logic [4:0] RESP_WERR = 5'h0D;
endpackage

// File: rtl/sdx_step_cnt.sv
module sdx_step_cnt #(
   parameter int LIMIT = 16,
   localparam int CW = $clog2(LIMIT)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clr,
   input  logic          step,
   output logic [CW-1:0] cnt
);
   if (LIMIT < 2) begin : g_bad_limit
      $error("sdx_step_cnt: LIMIT must be at least 2");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    cnt <= '0;
      else if (clr)  cnt <= '0;
      else if (step) cnt <= cnt + 1'b1;
   end
endmodule

// File: rtl/sdx_resp_decode.sv
module sdx_resp_decode
   import sdx_pkg::*;
(
   input  logic [4:0] tok,
   output logic       accepted,
   output logic [1:0] kind
);
   always_comb begin
      accepted = (tok == RESP_OK);
      if (tok == RESP_OK)        kind = 2'd0;
      else if (tok == RESP_CRC)  kind = 2'd1;
      else if (tok == RESP_WERR) kind = 2'd2;
      else                       kind = 2'd3;
   end
endmodule

// File: rtl/sd_blk_xfer.sv
module sd_blk_xfer
   import sdx_pkg::*;
#(
   parameter int BLK_LEN    = 512,
   parameter int HUNT_LIMIT = 4096,
   parameter int BUSY_LIMIT = 65536,
   localparam int IDX_W  = $clog2(BLK_LEN),
   localparam int HUNT_W = $clog2(HUNT_LIMIT),
   localparam int BUSY_W = $clog2(BUSY_LIMIT)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic             is_write,
   output logic             done,
   output logic             err_reject,
   output logic [1:0]       rej_kind,
   output logic             err_timeout,
   output logic             cs_n,
   output logic             xch_start,
   output logic [7:0]       xch_tx,
   input  logic             xch_done,
   input  logic [7:0]       xch_rx,
   output logic             rd_valid,
   output logic [IDX_W-1:0] rd_idx,
   output logic [7:0]       rd_data,
   output logic [IDX_W-1:0] wr_idx,
   input  logic [7:0]       wr_data
);
   if (BLK_LEN < 2 || (1 << IDX_W) != BLK_LEN) begin : g_bad_len
      $error("sd_blk_xfer: BLK_LEN must be a power of two >= 2");
   end
   if (HUNT_LIMIT < 2 || BUSY_LIMIT < 2) begin : g_bad_lim
      $error("sd_blk_xfer: poll limits must be at least 2");
   end

   sdx_state_t st;
   logic pend, crc_sec, rx_ok;
   logic [7:0] tx_sel;
   logic [IDX_W-1:0]  pay_cnt;
   logic [HUNT_W-1:0] hunt_cnt;
   logic [BUSY_W-1:0] busy_cnt;
   logic resp_ok;
   logic [1:0] resp_kind;
   logic pay_last, hunt_last, busy_last, cnt_clr;

   assign rx_ok     = pend && xch_done;
   assign cnt_clr   = (st == S_IDLE);
   assign pay_last  = (pay_cnt  == IDX_W'(BLK_LEN - 1));
   assign hunt_last = (hunt_cnt == HUNT_W'(HUNT_LIMIT - 1));
   assign busy_last = (busy_cnt == BUSY_W'(BUSY_LIMIT - 1));
   assign wr_idx    = pay_cnt;

   sdx_step_cnt #(.LIMIT(BLK_LEN)) u_pay (
      .clk(clk), .rst_n(rst_n), .clr(cnt_clr),
      .step(rx_ok && (st == S_RDAT || st == S_WDAT)), .cnt(pay_cnt));
   sdx_step_cnt #(.LIMIT(HUNT_LIMIT)) u_hunt (
      .clk(clk), .rst_n(rst_n), .clr(cnt_clr),
      .step(rx_ok && st == S_HUNT), .cnt(hunt_cnt));
   sdx_step_cnt #(.LIMIT(BUSY_LIMIT)) u_busy (
      .clk(clk), .rst_n(rst_n), .clr(cnt_clr),
      .step(rx_ok && st == S_WBSY), .cnt(busy_cnt));

   sdx_resp_decode u_dec (.tok(xch_rx[4:0]), .accepted(resp_ok), .kind(resp_kind));

   always_comb begin
      case (st)
         S_WTOK:  tx_sel = TOK_START;
         S_WDAT:  tx_sel = wr_data;
         default: tx_sel = FILL_BYTE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st          <= S_IDLE;
         pend        <= 1'b0;
         crc_sec     <= 1'b0;
         xch_start   <= 1'b0;
         xch_tx      <= FILL_BYTE;
         cs_n        <= 1'b1;
         done        <= 1'b0;
         err_reject  <= 1'b0;
         rej_kind    <= 2'd0;
         err_timeout <= 1'b0;
         rd_valid    <= 1'b0;
         rd_idx      <= '0;
         rd_data     <= '0;
      end else begin
         xch_start <= 1'b0;
         done      <= 1'b0;
         rd_valid  <= 1'b0;
         if (st == S_IDLE) begin
            if (start) begin
               err_reject  <= 1'b0;
               rej_kind    <= 2'd0;
               err_timeout <= 1'b0;
               cs_n        <= 1'b0;
               st          <= is_write ? S_WTOK : S_HUNT;
            end
         end else if (!pend) begin
            xch_start <= 1'b1;
            xch_tx    <= tx_sel;
            pend      <= 1'b1;
         end else if (xch_done) begin
            pend <= 1'b0;
            case (st)
               S_HUNT: begin
                  if (xch_rx == TOK_START) st <= S_RDAT;
                  else if (hunt_last) begin
                     err_timeout <= 1'b1;
                     cs_n        <= 1'b1;
                     st          <= S_TRAIL;
                  end
               end
               S_RDAT: begin
                  rd_valid <= 1'b1;
                  rd_data  <= xch_rx;
                  rd_idx   <= pay_cnt;
                  if (pay_last) st <= S_RCRC;
               end
               S_WTOK: st <= S_WDAT;
               S_WDAT: if (pay_last) st <= S_WCRC;
               S_RCRC, S_WCRC: begin
                  crc_sec <= ~crc_sec;
                  if (crc_sec) begin
                     if (st == S_WCRC) st <= S_WRSP;
                     else begin
                        cs_n <= 1'b1;
                        st   <= S_TRAIL;
                     end
                  end
               end
               S_WRSP: begin
                  if (resp_ok) st <= S_WBSY;
                  else begin
                     err_reject <= 1'b1;
                     rej_kind   <= resp_kind;
                     cs_n       <= 1'b1;
                     st         <= S_TRAIL;
                  end
               end
               S_WBSY: begin
                  if (xch_rx != 8'h00) begin
                     cs_n <= 1'b1;
                     st   <= S_TRAIL;
                  end else if (busy_last) begin
                     err_timeout <= 1'b1;
                     cs_n        <= 1'b1;
                     st          <= S_TRAIL;
                  end
               end
               default: begin
                  done <= 1'b1;
                  st   <= S_IDLE;
               end
            endcase
         end
      end
   end
endmodule

// File: rtl/sdx_checker.sv
module sdx_checker #(
   parameter int BLK_LEN = 512,
   localparam int IDX_W = $clog2(BLK_LEN)
) (
   input logic             clk,
   input logic             rst_n,
   input logic             start,
   input logic             done,
   input logic             cs_n,
   input logic             xch_start,
   input logic [7:0]       xch_tx,
   input logic             rd_valid,
   input logic [IDX_W-1:0] rd_idx,
   input logic             err_reject,
   input logic             err_timeout
);
   logic [IDX_W-1:0] last_idx;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        last_idx <= '0;
      else if (rd_valid) last_idx <= rd_idx;
   end

   assert_valid_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
      rd_valid |=> !rd_valid);
   assert_idx_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_valid && rd_idx != '0) |-> rd_idx == last_idx + 1'b1);
   assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
   assert_one_error_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !(err_reject && err_timeout));
   assert_done_cs_high_R7: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> cs_n);
   assert_trail_fill_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (xch_start && cs_n) |-> xch_tx == 8'hFF);
   assert_cs_drop_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(cs_n) |-> $past(start));
   assert_req_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
      xch_start |=> !xch_start);
endmodule

bind sd_blk_xfer sdx_checker #(.BLK_LEN(BLK_LEN)) u_chk (
   .clk(clk), .rst_n(rst_n), .start(start), .done(done), .cs_n(cs_n),
   .xch_start(xch_start), .xch_tx(xch_tx), .rd_valid(rd_valid),
   .rd_idx(rd_idx), .err_reject(err_reject), .err_timeout(err_timeout));

// File: tb/sim_sd_blk_xfer.sv
module sim_sd_blk_xfer;
   localparam int L  = 16;
   localparam int HL = 12;
   localparam int BL = 10;
   localparam int IW = $clog2(L);

   logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, is_write = 1'b0;
   logic done, err_reject, err_timeout, cs_n, xch_start, rd_valid;
   logic [1:0] rej_kind;
   logic [7:0] xch_tx, rd_data, wr_data;
   logic xch_done = 1'b0;
   logic [7:0] xch_rx = 8'hFF;
   logic [IW-1:0] rd_idx, wr_idx;

   always #4 clk = ~clk;

   int total = 0, bad = 0, cycles = 0;

   logic       sc_write;
   int         sc_hunt, sc_busy;
   logic [7:0] sc_fill, sc_resp;
   logic [7:0] sc_pay [L];
   logic [7:0] lg_tx [64];
   logic       lg_cs [64];
   int         lg_n = 0, rd_n = 0, dly = 0;

   assign wr_data = sc_pay[wr_idx];

   sd_blk_xfer #(.BLK_LEN(L), .HUNT_LIMIT(HL), .BUSY_LIMIT(BL)) u0 (
      .clk(clk), .rst_n(rst_n), .start(start), .is_write(is_write),
      .done(done), .err_reject(err_reject), .rej_kind(rej_kind),
      .err_timeout(err_timeout), .cs_n(cs_n), .xch_start(xch_start),
      .xch_tx(xch_tx), .xch_done(xch_done), .xch_rx(xch_rx),
      .rd_valid(rd_valid), .rd_idx(rd_idx), .rd_data(rd_data),
      .wr_idx(wr_idx), .wr_data(wr_data));

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic logic [7:0] card_byte(input int k);
      if (sc_write) begin
         if (k <= L + 2) return 8'hFF;
         if (k == L + 3) return sc_resp;
         return (k - (L + 4) < sc_busy) ? 8'h00 : 8'hFF;
      end
      if (k < sc_hunt)  return sc_fill;
      if (k == sc_hunt) return 8'hFE;
      if (k <= sc_hunt + L) return sc_pay[k - sc_hunt - 1];
      return 8'h3C;
   endfunction

   function automatic int kind_of(input logic [7:0] t);
      if (t[4:0] == 5'h0B) return 1;
      if (t[4:0] == 5'h0D) return 2;
      return 3;
   endfunction

   always @(negedge clk) begin
      cycles++;
      xch_done = 1'b0;
      if (dly > 0) begin
         dly--;
         if (dly == 0) begin
            xch_done = 1'b1;
            xch_rx = lg_cs[lg_n-1] ? 8'hFF : card_byte(lg_n - 1);
         end
      end
      if (xch_start) begin
         if (lg_n < 64) begin
            lg_tx[lg_n] = xch_tx;
            lg_cs[lg_n] = cs_n;
            lg_n++;
         end
         dly = 2;
      end
      if (rd_valid) begin
         chk(rd_idx == IW'(rd_n), "R11 index order", int'(rd_idx), rd_n);
         chk(rd_data == sc_pay[rd_idx], "R1 read byte", int'(rd_data), int'(sc_pay[rd_idx]));
         rd_n++;
      end
   end

   task automatic run_xfer();
      int n_exp, polls, w;
      bit timeo, rej, ok;
      lg_n = 0; rd_n = 0;
      @(negedge clk);
      start = 1'b1; is_write = sc_write;
      @(negedge clk);
      start = 1'b0;
      w = 0;
      while (!done && w < 3000) begin @(negedge clk); w++; end
      chk(w < 3000, "R10 done reached", w, 0);
      rej = 1'b0; timeo = 1'b0;
      if (!sc_write) begin
         timeo = (sc_hunt >= HL);
         polls = timeo ? HL : sc_hunt + 1;
         n_exp = polls + (timeo ? 0 : L + 2) + 1;
         chk(rd_n == (timeo ? 0 : L), "R2 payload count (check bytes dropped)", rd_n, timeo ? 0 : L);
         ok = 1'b1;
         for (int i = 0; i < n_exp && i < lg_n; i++) if (lg_tx[i] != 8'hFF) ok = 1'b0;
         chk(ok, timeo ? "R8 hunt polls" : "R1 poll bytes", 0, 0);
      end else begin
         rej = (sc_resp[4:0] != 5'h05);
         polls = rej ? 0 : (sc_busy < BL ? sc_busy + 1 : BL);
         timeo = !rej && sc_busy >= BL;
         n_exp = 1 + L + 2 + 1 + polls + 1;
         ok = (lg_tx[0] == 8'hFE);
         for (int i = 0; i < L; i++) if (lg_tx[1+i] != sc_pay[i]) ok = 1'b0;
         for (int i = L + 1; i < n_exp && i < lg_n; i++) if (lg_tx[i] != 8'hFF) ok = 1'b0;
         chk(ok, "R3 write byte stream", int'(lg_tx[0]), 8'hFE);
         if (rej) chk(rej_kind == 2'(kind_of(sc_resp)), "R5 reject kind", int'(rej_kind), kind_of(sc_resp));
      end
      chk(lg_n == n_exp, sc_write ? (rej ? "R5 no busy wait" : (timeo ? "R9 busy bound" : "R6 busy polls"))
                                  : (timeo ? "R8 hunt bound" : "R1 exchange count"), lg_n, n_exp);
      chk(err_reject == rej, "R4 accept/reject flag", int'(err_reject), int'(rej));
      chk(err_timeout == timeo, timeo ? "R9/R8 timeout flag" : "R6 no timeout", int'(err_timeout), int'(timeo));
      ok = (lg_n > 0) && lg_cs[lg_n-1];
      for (int i = 0; i + 1 < lg_n; i++) if (lg_cs[i]) ok = 1'b0;
      chk(ok, "R7 chip select framing", lg_n, n_exp);
   endtask

   task automatic set_pay();
      for (int i = 0; i < L; i++) sc_pay[i] = 8'($urandom);
   endtask

   initial begin
      void'($urandom(32'd4242));
      sc_write = 0; sc_hunt = 0; sc_busy = 0; sc_fill = 8'hFF; sc_resp = 8'hE5;
      set_pay();
      repeat (3) @(negedge clk);
      chk(cs_n == 1'b1 && done == 1'b0 && xch_start == 1'b0 && rd_valid == 1'b0
          && err_reject == 1'b0 && err_timeout == 1'b0, "R10 reset state", int'(cs_n), 1);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      // R1 directed reads: token at once, later, on last allowed poll
      sc_write = 0; sc_hunt = 0; set_pay(); run_xfer();
      sc_hunt = 5; sc_fill = 8'hFC; set_pay(); run_xfer();
      sc_hunt = HL - 1; sc_fill = 8'hFF; set_pay(); run_xfer();
      // R8 hunt timeout
      sc_hunt = HL; run_xfer();
      repeat (3) @(negedge clk);
      chk(err_timeout == 1'b1, "R10 flag held after done", int'(err_timeout), 1);
      // R4/R6 accepted writes, R9 busy bound
      sc_write = 1; sc_resp = 8'hE5; sc_busy = 0; set_pay(); run_xfer();
      sc_busy = BL - 1; set_pay(); run_xfer();
      sc_busy = BL; run_xfer();
      // R5 rejects
      sc_busy = 3; sc_resp = 8'h6B; run_xfer();
      sc_resp = 8'hAD; run_xfer();
      sc_resp = 8'h07; run_xfer();
      // constrained random mix
      for (int it = 0; it < 24; it++) begin
         sc_write = 1'($urandom);
         sc_hunt  = int'($urandom % 15);
         sc_busy  = int'($urandom % 12);
         sc_fill  = 8'($urandom);
         if (sc_fill == 8'hFE) sc_fill = 8'hFF;
         case ($urandom % 5)
            0: sc_resp = 8'h05;
            1: sc_resp = {3'($urandom), 5'h05};
            2: sc_resp = {3'($urandom), 5'h0B};
            3: sc_resp = {3'($urandom), 5'h0D};
            default: sc_resp = 8'($urandom);
         endcase
         set_pay();
         run_xfer();
      end
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      wait (cycles > 150000);
      bad++; total++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule